// File: doc/BRIEF.md
# Bidirectional Token-Scan Row Selector

This block picks which one of forty display rows is actively driven at any moment. A single-bit token enters through one of two token pins. It is placed at the first position of the selected scan order and moves one position further on every rising clock edge. The row that holds the token is driven. Every other row floats. Two mode pins choose between a straight end-to-end walk and a split walk that visits one half of the rows before the other, and they also choose which way the walk runs. The direction pin also decides which of the two token pins is the input and which one passes the token on to a chained device.

Each row output is a pair of signals: an enable that says the row is driven, and a value that says which rail it is driven to. A polarity input sets that value. An active-low output enable can float every row without disturbing the scan in progress. The cascade output repeats the token input forty clocks later, and it changes on the falling clock edge. A second device that samples on the following rising edge therefore continues the scan without a gap.

Top module: `tokscan_top`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the token is discarded. After that edge, every row_en_o bit and the cascade output are 0.
- R2: When the active token input is high at a rising edge, any token in flight is discarded and a single token is placed at position 0 of the scan order. This can happen at any time, including mid-scan and on consecutive edges.
- R3: With no restart, the token moves exactly one scan position per rising edge. After position 39 it leaves the block and is not recirculated, so every row floats until the next restart.
- R4: With dir_i=1, tok_a_i is the token input, tok_a_oe_o=0 and tok_b_oe_o=1. With dir_i=0, tok_b_i is the input, tok_a_oe_o=1 and tok_b_oe_o=0. A high level on the pin acting as output has no effect.
- R5: With shift=0, row n is bit n-1 of the row vectors. For dir=1 the scan visits rows 1,2,…,40. For dir=0 it visits rows 40,39,…,1.
- R6: With shift=1 and dir=1, the order is rows 21..40 ascending, then rows 1..20 ascending. With shift=1 and dir=0, the order is rows 20..1 descending, then rows 40..21 descending.
- R7: The cascade output, carried on both tok_a_o and tok_b_o, is 1 for the one clock in which the token is at position 39. It changes on the falling edge that follows the rising edge that moved the token there, so it rises 40 clocks after the token input was sampled.
- R8: The driven row has row_en_o=1, and its row_val_o equals pol_i. Rows that are not driven have row_en_o=0 and row_val_o=0.
- R9: When oe_n_i=1, every row_en_o and row_val_o bit is 0. The token keeps advancing, and the rows are driven again as soon as oe_n_i returns to 0.
- R10: The values of dir_i and shift_i that set the scan order are captured only at a restart or at reset. A change in the middle of a scan leaves the current token's order unchanged. The pin roles of R4 always follow the live dir_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; token sampled and moved on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Scan direction and token pin roles |
| shift_i | input | 1 | 0 = end-to-end walk, 1 = split-halves walk |
| pol_i | input | 1 | Level driven onto the selected row |
| oe_n_i | input | 1 | Active-low output enable for all rows |
| tok_a_i | input | 1 | Token pin A, input side |
| tok_a_o | output | 1 | Token pin A, output side (cascade) |
| tok_a_oe_o | output | 1 | Pin A driven as output |
| tok_b_i | input | 1 | Token pin B, input side |
| tok_b_o | output | 1 | Token pin B, output side (cascade) |
| tok_b_oe_o | output | 1 | Pin B driven as output |
| row_en_o | output | 40 | Per-row drive enable; bit n-1 is row n |
| row_val_o | output | 40 | Per-row drive value; bit n-1 is row n |

## Verification
The bench walks the token through all four orders. It checks the split orders at the seam between the two halves. A mapping that got the halves wrong would jump to the wrong row at the twenty-first step. It restarts the token mid-scan and on back-to-back edges: a design that did not clear the register would show two driven rows, or a stale cascade pulse forty clocks later. It toggles the mode pins mid-scan and pulses a token onto the pin that is acting as output. A design that applied the mode live would redirect the token partway through, and one with the pin roles swapped would start a scan from the wrong pin. The cascade is sampled after the falling edge at position 39 and again one clock later, which exposes an output that is a clock early or late, or a token that wraps back to the first row.

// File: rtl/tokscan_pkg.sv
package tokscan_pkg;

    // Scan configuration captured at restart
    typedef struct packed {
        logic dir;
        logic shift;
    } scan_mode_t;

endpackage

// File: rtl/tokscan_shifter.sv
module tokscan_shifter
    import tokscan_pkg::*;
#(
    parameter int NPOS = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart_i,
    input  scan_mode_t      mode_i,
    output logic [NPOS-1:0] sr_o,
    output scan_mode_t      mode_o,
    output logic            casc_o
);

    typedef struct packed {
        logic [NPOS-1:0] sr;
        scan_mode_t      mode;
    } shf_state_t;

    shf_state_t st_d, st_q;
    logic       casc_d, casc_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.sr   = '0;
            st_d.mode = mode_i;
        end else if (restart_i) begin
            st_d.sr    = '0;
            st_d.sr[0] = 1'b1;
            st_d.mode  = mode_i;
        end else begin
            st_d.sr = {st_q.sr[NPOS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Cascade becomes visible after the clock-high phase
    always_comb begin
        casc_d = rst ? 1'b0 : st_q.sr[NPOS-1];
    end

    always_ff @(negedge clk) begin
        casc_q <= casc_d;
    end

    assign sr_o   = st_q.sr;
    assign mode_o = st_q.mode;
    assign casc_o = casc_q;

    a_r2_restart_loads_first: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> sr_o == {{(NPOS-1){1'b0}}, 1'b1});

    a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
        !restart_i |=> sr_o == ($past(sr_o) << 1));

    a_r2_single_token: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sr_o));

    a_r10_mode_held: assert property (@(posedge clk) disable iff (rst)
        !restart_i |=> $stable(mode_o));

    a_r7_cascade_follows_last: assert property (@(posedge clk) disable iff (rst)
        casc_o == sr_o[NPOS-1]);

endmodule

// File: rtl/tokscan_rowmap.sv
module tokscan_rowmap
    import tokscan_pkg::*;
#(
    parameter int NROWS = 40
) (
    input  logic [NROWS-1:0] sr_i,
    input  scan_mode_t       mode_i,
    input  logic             pol_i,
    input  logic             oe_n_i,
    output logic [NROWS-1:0] en_o,
    output logic [NROWS-1:0] val_o
);

    localparam int HALF = NROWS / 2;

    logic [NROWS-1:0] v_fwd, v_rev, v_sfwd, v_srev;
    logic [NROWS-1:0] hit;

    // Each scan position lands on one row per variant
    for (genvar p = 0; p < NROWS; p++) begin : g_pos
        localparam int R_FWD  = p;
        localparam int R_REV  = NROWS - 1 - p;
        localparam int R_SFWD = (p < HALF) ? HALF + p : p - HALF;
        localparam int R_SREV = (p < HALF) ? HALF - 1 - p : NROWS - 1 - (p - HALF);
        assign v_fwd[R_FWD]   = sr_i[p];
        assign v_rev[R_REV]   = sr_i[p];
        assign v_sfwd[R_SFWD] = sr_i[p];
        assign v_srev[R_SREV] = sr_i[p];
    end

    always_comb begin
        unique case ({mode_i.shift, mode_i.dir})
            2'b01:   hit = v_fwd;
            2'b00:   hit = v_rev;
            2'b11:   hit = v_sfwd;
            default: hit = v_srev;
        endcase
        en_o  = hit & {NROWS{~oe_n_i}};
        val_o = en_o & {NROWS{pol_i}};
    end

endmodule

// File: rtl/tokscan_top.sv
module tokscan_top
    import tokscan_pkg::*;
#(
    parameter int NROWS = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_i,
    input  logic             shift_i,
    input  logic             pol_i,
    input  logic             oe_n_i,
    input  logic             tok_a_i,
    output logic             tok_a_o,
    output logic             tok_a_oe_o,
    input  logic             tok_b_i,
    output logic             tok_b_o,
    output logic             tok_b_oe_o,
    output logic [NROWS-1:0] row_en_o,
    output logic [NROWS-1:0] row_val_o
);

    scan_mode_t       mode_live, mode_q;
    logic [NROWS-1:0] sr;
    logic             restart;
    logic             casc;

    assign mode_live = '{dir: dir_i, shift: shift_i};
    assign restart   = dir_i ? tok_a_i : tok_b_i;

    tokscan_shifter #(.NPOS(NROWS)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .mode_i    (mode_live),
        .sr_o      (sr),
        .mode_o    (mode_q),
        .casc_o    (casc)
    );

    tokscan_rowmap #(.NROWS(NROWS)) u_map (
        .sr_i   (sr),
        .mode_i (mode_q),
        .pol_i  (pol_i),
        .oe_n_i (oe_n_i),
        .en_o   (row_en_o),
        .val_o  (row_val_o)
    );

    // Pin roles follow the live direction
    assign tok_a_oe_o = ~dir_i;
    assign tok_b_oe_o = dir_i;
    assign tok_a_o    = casc;
    assign tok_b_o    = casc;

    a_r9_disable_floats: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> (row_en_o == '0 && row_val_o == '0));

    a_r8_single_driven_row: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_en_o));

    a_r8_value_on_driven_only: assert property (@(posedge clk) disable iff (rst)
        (row_val_o & ~row_en_o) == '0);

    a_r4_pin_roles: assert property (@(posedge clk) disable iff (rst)
        $countones({tok_a_oe_o, tok_b_oe_o}) == 1 && (dir_i == tok_b_oe_o));

    a_r3_token_reaches_rows: assert property (@(posedge clk) disable iff (rst)
        (!oe_n_i && sr != '0) |-> row_en_o != '0);

endmodule

// File: tb/tokscan_top_bench.sv
module tokscan_top_bench;

    localparam int NR = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_i = 1'b1, shift_i = 1'b0, pol_i = 1'b1, oe_n_i = 1'b0;
    logic tok_a_i = 1'b0, tok_b_i = 1'b0;
    logic tok_a_o, tok_a_oe_o, tok_b_o, tok_b_oe_o;
    logic [NR-1:0] row_en_o, row_val_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int pos = -1;
    bit m_dir = 1'b1, m_shift = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    tokscan_top #(.NROWS(NR)) u_tokscan_top (
        .clk(clk), .rst(rst), .dir_i(dir_i), .shift_i(shift_i),
        .pol_i(pol_i), .oe_n_i(oe_n_i),
        .tok_a_i(tok_a_i), .tok_a_o(tok_a_o), .tok_a_oe_o(tok_a_oe_o),
        .tok_b_i(tok_b_i), .tok_b_o(tok_b_o), .tok_b_oe_o(tok_b_oe_o),
        .row_en_o(row_en_o), .row_val_o(row_val_o)
    );

    // 1-based row visited at scan step p
    function automatic int row_at(int p, bit d, bit s);
        int q[$];
        if (!s && d)       for (int r = 1; r <= 40; r++) q.push_back(r);
        else if (!s && !d) for (int r = 40; r >= 1; r--) q.push_back(r);
        else if (s && d) begin
            for (int r = 21; r <= 40; r++) q.push_back(r);
            for (int r = 1; r <= 20; r++) q.push_back(r);
        end else begin
            for (int r = 20; r >= 1; r--) q.push_back(r);
            for (int r = 40; r >= 21; r--) q.push_back(r);
        end
        return q[p];
    endfunction

    task automatic chk(string req, string what, logic [NR-1:0] act, logic [NR-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: apply inputs, advance model, compare rows then cascade
    task automatic cyc(bit ta, bit tb, bit r);
        logic [NR-1:0] e;
        bit tin;
        tok_a_i = ta; tok_b_i = tb; rst = r;
        tin = dir_i ? ta : tb;
        @(posedge clk);
        if (r) begin
            pos = -1; m_dir = dir_i; m_shift = shift_i;
        end else if (tin) begin
            pos = 0; m_dir = dir_i; m_shift = shift_i;
        end else if (pos >= 0) begin
            pos++;
            if (pos == 40) pos = -1;
        end
        #4;
        e = '0;
        if (pos >= 0 && !oe_n_i) e[row_at(pos, m_dir, m_shift) - 1] = 1'b1;
        chk(tag, "row_en", row_en_o, e);
        chk(tag, "row_val", row_val_o, pol_i ? e : '0);
        chk("R4", "pin_oe", {38'd0, tok_a_oe_o, tok_b_oe_o}, {38'd0, ~dir_i, dir_i});
        @(negedge clk);
        #2;
        chk("R7", "cascade", {39'd0, (dir_i ? tok_b_o : tok_a_o)}, {39'd0, pos == 39});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    task automatic start();
        if (dir_i) cyc(1, 0, 0); else cyc(0, 1, 0);
    endtask

    initial begin
        @(negedge clk); #2;
        tag = "R1"; cyc(0, 0, 1); cyc(0, 0, 1);
        idle(2);

        tag = "R5"; dir_i = 1; shift_i = 0; pol_i = 1;
        start(); idle(42);
        tag = "R5"; dir_i = 0; pol_i = 0;
        start(); idle(42);

        tag = "R6"; dir_i = 1; shift_i = 1; pol_i = 1;
        start(); idle(42);
        tag = "R6"; dir_i = 0;
        start(); idle(42);

        tag = "R3"; dir_i = 1; shift_i = 0;
        start(); idle(45);

        tag = "R4"; dir_i = 1;
        cyc(0, 1, 0); idle(3);           // B is output: ignored
        dir_i = 0; cyc(1, 0, 0); idle(3); // A is output: ignored

        tag = "R2"; dir_i = 1;
        start(); idle(10); start(); start(); idle(15); start(); idle(42);

        tag = "R9";
        start(); idle(5); oe_n_i = 1; idle(6); oe_n_i = 0; idle(5);
        tag = "R8"; pol_i = 0; idle(4); pol_i = 1; idle(25);

        tag = "R10"; dir_i = 1; shift_i = 0;
        start(); idle(6); shift_i = 1; idle(6); dir_i = 0; idle(30);
        start(); idle(42);
        shift_i = 1; dir_i = 1; start(); idle(41);

        tag = "R1"; start(); idle(8); cyc(0, 0, 1); idle(40);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule